// File: doc/BRIEF.md
# Ethernet Transmit Pause and Stop Controller

This block decides, frame by frame, what a simple Ethernet MAC transmitter sends next. It sits between the head of the transmit frame queue and the transmit engine. It issues a one-cycle start for a data frame or for a MAC control pause frame, and it waits for the engine's done, collision or pause-done reply. A four-bit control register carries four requests:

- a send-pause request,
- a graceful-stop request,
- full-duplex operation,
- heartbeat checking.

A pause frame from the receive side, carrying a quanta count, halts data frames until a quantum tick input has counted that duration down. Every request takes effect only at a frame boundary. A control pause frame may still go out while data frames are held back.

The sequencer has four named states:

- IDLE (`ST_IDLE`) chooses what to send next.
- DATA (`ST_DATA`) means a data frame is in flight.
- PAUSE_TX (`ST_PAUSE_TX`) means a control pause frame is in flight.
- HALT (`ST_HALT`) means graceful stop holds.

The transitions are:

| From | To | Condition | Outputs |
|---|---|---|---|
| IDLE | PAUSE_TX | send-pause is pending and the line is free | stop interrupt and pause start |
| IDLE | HALT | graceful stop is set | stop interrupt |
| IDLE | DATA | a frame is queued, no pause is pending, no received pause is running, and the line is free | frame start |
| DATA | IDLE | the engine reports done or an early collision | none |
| PAUSE_TX | IDLE | pause-done | send-pause clears itself |
| HALT | PAUSE_TX | send-pause is pending and the line is free | pause start |
| HALT | IDLE | graceful stop is cleared | none |

When the machine returns to IDLE with graceful stop still set, it moves on to HALT and raises a fresh stop interrupt.

Top module: `eth_txflow_ctrl`

## Requirements
- R1: After reset, the control readback `cfg_rdata` is 0, `rx_paused` and `hb_err` are 0, and no start or interrupt pulse is output. The readback bit positions are: bit 0 send-pause, bit 1 graceful stop, bit 2 full duplex, bit 3 heartbeat check.
- R2: A write updates bits 2 and 3 only while `mac_en` is low. With `mac_en` high those two bits keep their value, and bits 0 and 1 are still written.
- R3: A send-pause request made during a data frame lets that frame finish. At the next boundary the block outputs `stop_irq` and `pause_start` in the same cycle. On `pause_done` readback bit 0 clears by itself, and queued data frames then start again.
- R4: A graceful stop set during a data frame starts no further data frame. `stop_irq` pulses only after that frame's `frm_done`.
- R5: A graceful stop set with no frame in flight raises `stop_irq` two cycles after the write cycle.
- R6: Clearing graceful stop lets the queued frame start.
- R7: An early collision (`frm_coll`) while graceful stop is set halts the transmitter with a `stop_irq`. Once graceful stop clears, the same queued frame is started again.
- R8: A send-pause request is served while data is halted, whether by graceful stop or by a received pause. When the pause frame ends, bit 0 clears and data stays halted.
- R9: In full duplex, a received pause with a nonzero quanta sets `rx_paused` and blocks data starts. Each `quantum_tick` counts the duration down by one, and `rx_paused` clears when it reaches zero. A received quanta of 0 ends the pause at once. A received pause is ignored in half duplex.
- R10: In half duplex a frame starts only while `crs` and `col` are both low. In full duplex, `crs` and `col` are ignored when starting a frame.
- R11: With heartbeat check on, `hb_err` sets if `col` stays low for the `HB_WIN` cycles that follow the cycle of `frm_done`. It stays low if `col` asserts in that window, and once set it stays set until `hb_err_clr`.
- R12: `stop_irq` is a single-cycle pulse for each stop event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mac_en | input | 1 | MAC enable; gates sequencing and locks the mode bits |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 4 | Control write data: [0] send-pause, [1] graceful stop, [2] full duplex, [3] heartbeat check |
| cfg_rdata | output | 4 | Control register readback, same layout as the write data |
| hb_err_clr | input | 1 | Write-one clear of the heartbeat error |
| q_valid | input | 1 | The transmit queue holds a frame at its head |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision |
| frm_start | output | 1 | One-cycle start of the head data frame |
| frm_done | input | 1 | The data frame completed; the queue pops its head |
| frm_coll | input | 1 | The data frame was aborted by an early collision; the head stays queued |
| pause_start | output | 1 | One-cycle start of a MAC control pause frame |
| pause_done | input | 1 | The pause frame completed |
| rx_pause_evt | input | 1 | A pause frame was received |
| rx_pause_quanta | input | QW | Pause duration of the received frame, in quanta |
| quantum_tick | input | 1 | One pulse for each pause quantum (512 bit times) |
| stop_irq | output | 1 | Graceful-stop-complete interrupt pulse |
| rx_paused | output | 1 | Read-only status: received pause in effect |
| hb_err | output | 1 | Sticky heartbeat error status |

## Verification
A send-pause request and a graceful stop can both be waiting at the same frame boundary. In that case the stop interrupt and the pause start fall in the same cycle. The bench provokes this by writing both bits while halted, and by writing send-pause during a received pause. A scoreboard takes each cycle's output pulses in a fixed order (interrupt, pause, data) and compares them with the queued expectation, so a missing, extra or reordered pulse is reported. A tick and a new received pause in the same cycle are settled in favour of the new pause. The bench judges this through `rx_paused`.

// File: rtl/txpc_pkg.sv
`timescale 1ns/1ps
package txpc_pkg;
    localparam int CFG_W     = 4;
    localparam int CB_SPAUSE = 0;
    localparam int CB_GSTOP  = 1;
    localparam int CB_FDX    = 2;
    localparam int CB_HBCHK  = 3;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_DATA     = 2'd1,
        ST_PAUSE_TX = 2'd2,
        ST_HALT     = 2'd3
    } seq_state_t;
endpackage

// File: rtl/txpc_cfg_reg.sv
`timescale 1ns/1ps
module txpc_cfg_reg
    import txpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mac_en,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    input  logic             sp_done,
    output logic             sp,
    output logic             gs,
    output logic             fdx,
    output logic             hbchk
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp    <= 1'b0;
            gs    <= 1'b0;
            fdx   <= 1'b0;
            hbchk <= 1'b0;
        end else begin
            if (sp_done) sp <= 1'b0;
            if (wr) begin
                sp <= wdata[CB_SPAUSE];
                gs <= wdata[CB_GSTOP];
                if (!mac_en) begin
                    fdx   <= wdata[CB_FDX];
                    hbchk <= wdata[CB_HBCHK];
                end
            end
        end
    end

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        mac_en |=> ($stable(fdx) && $stable(hbchk))); // R2
endmodule

// File: rtl/txpc_pause_timer.sv
`timescale 1ns/1ps
module txpc_pause_timer #(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fdx,
    input  logic          evt,
    input  logic [QW-1:0] quanta,
    input  logic          tick,
    output logic          paused
);
    logic [QW-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (evt && fdx) begin
            remain <= quanta;
        end else if (tick && (remain != '0)) begin
            remain <= remain - 1'b1;
        end
    end

    assign paused = (remain != '0);

    AST_RXP_ZERO_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && fdx && (quanta == '0)) |=> !paused); // R9
    AST_RXP_HALFDUP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !fdx && !tick) |=> $stable(paused)); // R9
    AST_RXP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && !tick && !evt) |=> paused); // R9
endmodule

// File: rtl/txpc_hb_mon.sv
`timescale 1ns/1ps
module txpc_hb_mon #(
    parameter int HB_WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hb_en,
    input  logic tx_end,
    input  logic col,
    input  logic clr,
    output logic hb_err
);
    localparam int HW = $clog2(HB_WIN + 1);

    logic [HW-1:0] win_left;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_left <= '0;
        end else if (tx_end && hb_en) begin
            win_left <= HW'(HB_WIN);
        end else if (win_left != '0) begin
            if (col) win_left <= '0;
            else     win_left <= win_left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hb_err <= 1'b0;
        end else begin
            if (clr) hb_err <= 1'b0;
            if ((win_left == HW'(1)) && !col) hb_err <= 1'b1;
        end
    end

    AST_HB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_err && !clr) |=> hb_err); // R11
    AST_HB_COL_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        ((win_left != '0) && col && !hb_err) |=> !hb_err); // R11
endmodule

// File: rtl/txpc_seq.sv
`timescale 1ns/1ps
module txpc_seq
    import txpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mac_en,
    input  logic sp,
    input  logic gs,
    input  logic fdx,
    input  logic rx_paused,
    input  logic q_valid,
    input  logic crs,
    input  logic col,
    input  logic frm_done,
    input  logic frm_coll,
    input  logic pause_done,
    output logic frm_start,
    output logic pause_start,
    output logic stop_irq,
    output logic sp_done,
    output logic tx_end
);
    seq_state_t state, nxt;
    logic line_free;
    logic go_data, go_pause, go_irq;

    assign line_free = fdx || (!crs && !col);
    assign sp_done   = (state == ST_PAUSE_TX) && pause_done;
    assign tx_end    = (state == ST_DATA) && frm_done;

    always_comb begin
        nxt      = state;
        go_data  = 1'b0;
        go_pause = 1'b0;
        go_irq   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (mac_en) begin
                    if (sp && line_free) begin
                        nxt      = ST_PAUSE_TX;
                        go_pause = 1'b1;
                        go_irq   = 1'b1;
                    end else if (gs) begin
                        nxt    = ST_HALT;
                        go_irq = 1'b1;
                    end else if (!sp && !rx_paused && q_valid && line_free) begin
                        nxt     = ST_DATA;
                        go_data = 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (frm_done || frm_coll) nxt = ST_IDLE;
            end
            ST_PAUSE_TX: begin
                if (pause_done) nxt = ST_IDLE;
            end
            ST_HALT: begin
                if (sp && line_free) begin
                    nxt      = ST_PAUSE_TX;
                    go_pause = 1'b1;
                end else if (!gs) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_start   <= 1'b0;
            pause_start <= 1'b0;
            stop_irq    <= 1'b0;
        end else begin
            frm_start   <= go_data;
            pause_start <= go_pause;
            stop_irq    <= go_irq;
        end
    end

    AST_START_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(frm_start && pause_start)); // R3
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_irq |=> !stop_irq); // R12
    AST_START_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        frm_start |-> $past(line_free)); // R10
    AST_HALT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> !frm_start); // R4
    AST_RXP_BLOCKS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && rx_paused) |=> !frm_start); // R9
endmodule

// File: rtl/eth_txflow_ctrl.sv
`timescale 1ns/1ps
module eth_txflow_ctrl
    import txpc_pkg::*;
#(
    parameter int QW     = 16,
    parameter int HB_WIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mac_en,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             hb_err_clr,
    input  logic             q_valid,
    input  logic             crs,
    input  logic             col,
    output logic             frm_start,
    input  logic             frm_done,
    input  logic             frm_coll,
    output logic             pause_start,
    input  logic             pause_done,
    input  logic             rx_pause_evt,
    input  logic [QW-1:0]    rx_pause_quanta,
    input  logic             quantum_tick,
    output logic             stop_irq,
    output logic             rx_paused,
    output logic             hb_err
);
    logic sp, gs, fdx, hbchk;
    logic sp_done, tx_end;

    txpc_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .mac_en  (mac_en),
        .wr      (cfg_wr),
        .wdata   (cfg_wdata),
        .sp_done (sp_done),
        .sp      (sp),
        .gs      (gs),
        .fdx     (fdx),
        .hbchk   (hbchk)
    );

    txpc_pause_timer #(.QW(QW)) u_ptmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .fdx    (fdx),
        .evt    (rx_pause_evt),
        .quanta (rx_pause_quanta),
        .tick   (quantum_tick),
        .paused (rx_paused)
    );

    txpc_hb_mon #(.HB_WIN(HB_WIN)) u_hb (
        .clk    (clk),
        .rst_n  (rst_n),
        .hb_en  (hbchk),
        .tx_end (tx_end),
        .col    (col),
        .clr    (hb_err_clr),
        .hb_err (hb_err)
    );

    txpc_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .mac_en      (mac_en),
        .sp          (sp),
        .gs          (gs),
        .fdx         (fdx),
        .rx_paused   (rx_paused),
        .q_valid     (q_valid),
        .crs         (crs),
        .col         (col),
        .frm_done    (frm_done),
        .frm_coll    (frm_coll),
        .pause_done  (pause_done),
        .frm_start   (frm_start),
        .pause_start (pause_start),
        .stop_irq    (stop_irq),
        .sp_done     (sp_done),
        .tx_end      (tx_end)
    );

    always_comb begin
        cfg_rdata            = '0;
        cfg_rdata[CB_SPAUSE] = sp;
        cfg_rdata[CB_GSTOP]  = gs;
        cfg_rdata[CB_FDX]    = fdx;
        cfg_rdata[CB_HBCHK]  = hbchk;
    end

    AST_SP_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_done && !cfg_wr) |=> !cfg_rdata[CB_SPAUSE]); // R3
endmodule

// File: tb/tb_eth_txflow_ctrl.sv
`timescale 1ns/1ps
module tb_eth_txflow_ctrl;
    localparam int QW     = 16;
    localparam int HB_WIN = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mac_en = 1'b0, cfg_wr = 1'b0, hb_err_clr = 1'b0;
    logic [3:0]    cfg_wdata = '0, cfg_rdata;
    logic          q_valid = 1'b0, crs = 1'b0, col = 1'b0;
    logic          frm_done = 1'b0, frm_coll = 1'b0, pause_done = 1'b0;
    logic          rx_pause_evt = 1'b0, quantum_tick = 1'b0;
    logic [QW-1:0] rx_pause_quanta = '0;
    logic          frm_start, pause_start, stop_irq, rx_paused, hb_err;

    int  checks = 0;
    int  errors = 0;
    byte exp_q[$];
    logic [3:0] md;

    always #2.5 clk = ~clk;

    eth_txflow_ctrl #(.QW(QW), .HB_WIN(HB_WIN)) dut (
        .clk(clk), .rst_n(rst_n), .mac_en(mac_en), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hb_err_clr(hb_err_clr),
        .q_valid(q_valid), .crs(crs), .col(col), .frm_start(frm_start),
        .frm_done(frm_done), .frm_coll(frm_coll), .pause_start(pause_start),
        .pause_done(pause_done), .rx_pause_evt(rx_pause_evt),
        .rx_pause_quanta(rx_pause_quanta), .quantum_tick(quantum_tick),
        .stop_irq(stop_irq), .rx_paused(rx_paused), .hb_err(hb_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input byte c);
        exp_q.push_back(c);
    endtask

    task automatic wr_cfg(input logic [3:0] v);
        cfg_wdata = v;
        cfg_wr    = 1'b1;
        step(1);
        cfg_wr    = 1'b0;
    endtask

    task automatic end_frame();
        frm_done = 1'b1;
        step(1);
        frm_done = 1'b0;
    endtask

    task automatic qtick();
        quantum_tick = 1'b1;
        step(1);
        quantum_tick = 1'b0;
        step(1);
    endtask

    // Scoreboard monitor: pulses compared in order irq, pause, data
    task automatic seen(input byte c);
        byte e;
        checks++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R3/R4/R6/R8 event order: actual=%c expected=none", c);
        end else begin
            e = exp_q.pop_front();
            if (e != c) begin
                errors++;
                $display("FAIL R3/R4/R6/R8 event order: actual=%c expected=%c", c, e);
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (stop_irq)    seen("I");
            if (pause_start) seen("P");
            if (frm_start)   seen("D");
        end
    end

    initial begin
        int cyc = 0;
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=done", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk(cfg_rdata == 4'h0, "R1 cfg", cfg_rdata, 0);
        chk(!rx_paused && !hb_err, "R1 status", {rx_paused, hb_err}, 0);
        chk(!frm_start && !pause_start && !stop_irq, "R1 pulses", {frm_start, pause_start, stop_irq}, 0);

        // R2 mode bits locked while enabled
        wr_cfg(4'b0100);
        step(1);
        chk(cfg_rdata == 4'b0100, "R2 write disabled", cfg_rdata, 4'b0100);
        mac_en = 1'b1;
        wr_cfg(4'b1000);
        step(1);
        chk(cfg_rdata == 4'b0100, "R2 write enabled ignored", cfg_rdata, 4'b0100);
        md = 4'b0100;

        // R10 full duplex ignores carrier
        crs = 1'b1;
        push("D");
        q_valid = 1'b1;
        step(2);
        q_valid = 1'b0;
        step(2);
        end_frame();
        crs = 1'b0;
        step(2);

        // R3 send pause during frame
        push("D");
        q_valid = 1'b1;
        step(1);
        q_valid = 1'b0;
        step(1);
        push("I"); push("P");
        wr_cfg(md | 4'b0001);
        step(1);
        end_frame();
        step(2);
        chk(cfg_rdata[0] == 1'b1, "R3 pending during pause frame", cfg_rdata[0], 1);
        step(2);
        pause_done = 1'b1;
        step(1);
        pause_done = 1'b0;
        chk(cfg_rdata[0] == 1'b0, "R3 self clear", cfg_rdata[0], 0);
        push("D");
        q_valid = 1'b1;
        step(2);
        q_valid = 1'b0;
        step(1);
        end_frame();
        step(2);

        // R5 graceful stop while idle, R12 pulse width
        push("I");
        wr_cfg(md | 4'b0010);
        step(1);
        chk(stop_irq == 1'b1, "R5 immediate irq", stop_irq, 1);
        step(1);
        chk(stop_irq == 1'b0, "R12 one cycle", stop_irq, 0);
        q_valid = 1'b1;
        step(3);
        chk(frm_start == 1'b0, "R4 halted no start", frm_start, 0);
        // R6 restart on clear
        push("D");
        wr_cfg(md);
        step(3);
        q_valid = 1'b0;
        end_frame();
        step(2);

        // R4 graceful stop during frame
        push("D");
        q_valid = 1'b1;
        step(1);
        push("I");
        wr_cfg(md | 4'b0010);
        step(2);
        chk(stop_irq == 1'b0, "R4 no irq mid frame", stop_irq, 0);
        end_frame();
        step(1);
        step(3);
        chk(frm_start == 1'b0, "R4 no next frame", frm_start, 0);
        push("D");
        wr_cfg(md);
        step(3);
        q_valid = 1'b0;
        end_frame();
        step(2);

        // R7 collision under graceful stop, retry after clear
        push("D");
        q_valid = 1'b1;
        step(1);
        wr_cfg(md | 4'b0010);
        step(1);
        push("I");
        frm_coll = 1'b1;
        step(1);
        frm_coll = 1'b0;
        step(5);
        chk(frm_start == 1'b0, "R7 halted after collision", frm_start, 0);
        push("D");
        wr_cfg(md);
        step(3);
        q_valid = 1'b0;
        end_frame();
        step(2);

        // R8 pause frame while graceful stop holds
        push("I");
        wr_cfg(md | 4'b0010);
        step(2);
        push("P");
        wr_cfg(md | 4'b0011);
        step(3);
        chk(cfg_rdata[0] == 1'b1, "R8 pause pending", cfg_rdata[0], 1);
        push("I");
        pause_done = 1'b1;
        step(1);
        pause_done = 1'b0;
        step(2);
        chk(cfg_rdata == (md | 4'b0010), "R8 bit clears, stop holds", cfg_rdata, md | 4'b0010);
        wr_cfg(md);
        step(3);

        // R9 received pause counts down
        rx_pause_quanta = 16'd3;
        rx_pause_evt = 1'b1;
        step(1);
        rx_pause_evt = 1'b0;
        chk(rx_paused == 1'b1, "R9 sets", rx_paused, 1);
        q_valid = 1'b1;
        step(3);
        qtick();
        qtick();
        chk(rx_paused == 1'b1, "R9 still paused", rx_paused, 1);
        push("D");
        quantum_tick = 1'b1;
        step(1);
        quantum_tick = 1'b0;
        chk(rx_paused == 1'b0, "R9 expires", rx_paused, 0);
        step(2);
        q_valid = 1'b0;
        end_frame();
        step(2);

        // R8 pause frame during received pause; R9 zero quanta
        rx_pause_quanta = 16'd10;
        rx_pause_evt = 1'b1;
        step(1);
        rx_pause_evt = 1'b0;
        push("I"); push("P");
        wr_cfg(md | 4'b0001);
        step(3);
        pause_done = 1'b1;
        step(1);
        pause_done = 1'b0;
        step(1);
        chk(cfg_rdata[0] == 1'b0 && rx_paused, "R8 pause during rx pause", {cfg_rdata[0], rx_paused}, 1);
        rx_pause_quanta = 16'd0;
        rx_pause_evt = 1'b1;
        step(1);
        rx_pause_evt = 1'b0;
        chk(rx_paused == 1'b0, "R9 zero quanta", rx_paused, 0);
        step(2);

        // R10 half duplex gating, R9 ignored in half duplex
        mac_en = 1'b0;
        md = 4'b1000;
        wr_cfg(md);
        mac_en = 1'b1;
        rx_pause_quanta = 16'd5;
        rx_pause_evt = 1'b1;
        step(1);
        rx_pause_evt = 1'b0;
        chk(rx_paused == 1'b0, "R9 half duplex ignored", rx_paused, 0);
        crs = 1'b1;
        q_valid = 1'b1;
        step(4);
        chk(frm_start == 1'b0, "R10 carrier blocks", frm_start, 0);
        push("D");
        crs = 1'b0;
        step(2);
        q_valid = 1'b0;
        step(1);

        // R11 heartbeat missing
        end_frame();
        chk(hb_err == 1'b0, "R11 window open", hb_err, 0);
        step(HB_WIN + 3);
        chk(hb_err == 1'b1, "R11 missing heartbeat", hb_err, 1);
        step(3);
        chk(hb_err == 1'b1, "R11 sticky", hb_err, 1);
        hb_err_clr = 1'b1;
        step(1);
        hb_err_clr = 1'b0;
        chk(hb_err == 1'b0, "R11 clear", hb_err, 0);
        // R11 heartbeat seen
        push("D");
        q_valid = 1'b1;
        step(2);
        q_valid = 1'b0;
        step(1);
        end_frame();
        col = 1'b1;
        step(1);
        col = 1'b0;
        step(HB_WIN + 3);
        chk(hb_err == 1'b0, "R11 heartbeat seen", hb_err, 0);

        step(5);
        chk(exp_q.size() == 0, "R3/R6/R7 all expected events seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule